// File: doc/BRIEF.md
# Write Buffer with Read Check

This block sits between a write-through cache and the next memory level. The processor hands it stores, and it keeps them in a small in-order queue, so a store never waits for memory unless the queue is full. The queued stores go to memory one at a time, oldest first, over a single memory port. Read misses from the cache share that same port.

Read misses take priority over queued stores. Before a read goes out, its address is compared with every queued store. If any queued store matches, the data of the youngest matching store is returned straight away and memory is not touched. If none matches, the read is sent to memory ahead of the older stores. This is safe because none of them writes that address. A store taking up the slot that frees when a queued store drains is handled like any other store. Each store gets its own slot, even if its address is already queued.

Top module: `wbuf_top`

## Requirements
- R1: After reset the queue is empty: `st_ready`=1, `rd_ready`=1, `mem_valid`=0, `rd_rsp_valid`=0.
- R2: A store is taken (`st_valid`&&`st_ready` at a clock edge) whenever fewer than DEPTH (default 4) stores are queued. `st_ready` is 0 exactly while DEPTH stores are queued.
- R3: Queued stores reach memory oldest first. Each store is one memory write (`mem_we`=1) with its own address and data, and is sent exactly once.
- R4: When no memory access is in flight, no read is requested and the queue is not empty, a write of the oldest store is presented on the memory port in the next cycle.
- R5: A read whose address matches a queued store returns the data of the youngest matching store. `rd_rsp_valid` is 1 for exactly one cycle, the cycle after the read is taken, and no memory read is issued for it.
- R6: A read that matches no queued store presents a memory read (`mem_valid`=1, `mem_we`=0, its address) in the cycle after it is taken, even when older stores are still queued.
- R7: The cycle after `mem_rvalid`=1 for an outstanding read, `rd_rsp_valid` is 1 and `rd_rsp_data` equals that `mem_rdata`.
- R8: Two stores to the same address occupy two slots, and both are written to memory in order.
- R9: A store taken in the same cycle as a read is younger than that read and is not forwarded to it.
- R10: `rd_ready` is 0 while a memory read is outstanding, and 1 while the port is idle. While `mem_valid`=1 and `mem_ready`=0, `mem_addr`, `mem_we` and `mem_wdata` hold steady. A read that hits is still taken while a write waits on the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Queue can take a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| rd_valid | input | 1 | Read miss request |
| rd_ready | output | 1 | Read request taken this cycle |
| rd_addr | input | AW | Read address |
| rd_rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rd_rsp_data | output | DW | Read data |
| mem_valid | output | 1 | Memory request presented |
| mem_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Read data from memory, at least one cycle after the read is taken |
| mem_rdata | input | DW | Memory read data |

## Verification
A single store with a free-running memory shows the basic drain timing. A burst against a stalled memory fills the queue, which exposes the full condition. Because that burst repeats an address, it also shows whether forwarding picks the youngest copy or an older one. A read miss held during the stall must win the first idle slot while older stores wait, which separates read priority from plain in-order service. A store and a read to the same address in the same cycle show whether a same-cycle store wrongly leaks into the read. A long random mix over eight addresses, with a periodically busy memory, compares every forwarded and memory-sourced result against a queue-based model.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE,
    ARB_WR,
    ARB_RDREQ,
    ARB_RDWAIT
  } arb_state_e;
endpackage

// File: rtl/wbuf_fifo.sv
// Store queue: circular buffer whose slots are all visible for address compare.
module wbuf_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [AW-1:0]             push_addr,
  input  logic [DW-1:0]             push_data,
  input  logic                      pop,
  output logic [PW-1:0]             head,
  output logic [CW-1:0]             count,
  output logic                      full,
  output logic                      empty,
  output logic [AW-1:0]             head_addr,
  output logic [DW-1:0]             head_data,
  output logic [DEPTH-1:0][AW-1:0]  ent_addr,
  output logic [DEPTH-1:0][DW-1:0]  ent_data
);
  logic [PW-1:0] tail;

  assign tail      = head + count[PW-1:0];
  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign head_addr = ent_addr[head];
  assign head_data = ent_data[head];

  // payload slots carry no reset
  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[tail] <= push_addr;
      ent_data[tail] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      count <= '0;
    end else begin
      if (pop) head <= head + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/wbuf_match.sv
// Compares a read address with every live slot; the youngest match wins.
module wbuf_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic [PW-1:0]            head,
  input  logic [CW-1:0]            count,
  input  logic [AW-1:0]            q_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);
  logic [PW-1:0] idx;

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    idx      = '0;
    // walk oldest to youngest so a later match overrides an earlier one
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if ((CW'(k) < count) && (ent_addr[idx] == q_addr)) begin
        hit      = 1'b1;
        hit_data = ent_data[idx];
      end
    end
  end
endmodule

// File: rtl/wbuf_arb.sv
// Memory port owner: reads win the idle slot, drains fill the rest.
module wbuf_arb
  import wbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          hit,
  input  logic [DW-1:0] hit_data,
  input  logic          empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          rd_ready,
  output logic          pop,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  arb_state_e state;

  // a hitting read needs no port, so it is taken even while a write waits
  assign rd_ready = (state == ARB_IDLE) || ((state == ARB_WR) && hit);
  assign pop      = (state == ARB_WR) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ARB_IDLE;
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ARB_IDLE: begin
          if (rd_valid) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_data  <= hit_data;
            end else begin
              mem_valid <= 1'b1;
              mem_we    <= 1'b0;
              mem_addr  <= rd_addr;
              state     <= ARB_RDREQ;
            end
          end else if (!empty) begin
            mem_valid <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= head_addr;
            mem_wdata <= head_data;
            state     <= ARB_WR;
          end
        end
        ARB_WR: begin
          if (rd_valid && hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= hit_data;
          end
          if (mem_ready) begin
            mem_valid <= 1'b0;
            state     <= ARB_IDLE;
          end
        end
        ARB_RDREQ: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            state     <= ARB_RDWAIT;
          end
        end
        ARB_RDWAIT: begin
          if (mem_rvalid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem_rdata;
            state     <= ARB_IDLE;
          end
        end
        default: state <= ARB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_rsp_valid,
  output logic [DW-1:0] rd_rsp_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic                     push, pop, full, empty, hit;
  logic [PW-1:0]            head;
  logic [CW-1:0]            count;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data, hit_data;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;

  assign st_ready = !full;
  assign push     = st_valid && !full;

  wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_addr(st_addr), .push_data(st_data),
    .pop(pop), .head(head), .count(count), .full(full), .empty(empty),
    .head_addr(head_addr), .head_data(head_data),
    .ent_addr(ent_addr), .ent_data(ent_data)
  );

  wbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .ent_addr(ent_addr), .ent_data(ent_data), .head(head), .count(count),
    .q_addr(rd_addr), .hit(hit), .hit_data(hit_data)
  );

  wbuf_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .hit(hit), .hit_data(hit_data), .empty(empty),
    .head_addr(head_addr), .head_data(head_data),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rd_ready(rd_ready), .pop(pop), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data)
  );
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          st_valid,
  input logic          st_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          rd_rsp_valid,
  input logic [DW-1:0] rd_rsp_data,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rvalid,
  input logic [DW-1:0] mem_rdata
);
  logic [CW-1:0] fill;
  logic          rd_wait;
  logic          rst_q;

  // occupancy and outstanding-read state rebuilt from port handshakes
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      fill    <= '0;
      rd_wait <= 1'b0;
    end else begin
      fill <= fill + CW'(st_valid && st_ready) - CW'(mem_valid && mem_ready && mem_we);
      if (mem_valid && mem_ready && !mem_we) rd_wait <= 1'b1;
      else if (mem_rvalid) rd_wait <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (rst_q && !rst) begin
      a_r1_idle_after_reset: assert (st_ready && rd_ready && !mem_valid && !rd_rsp_valid);
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (fill <= CW'(DEPTH)) && (st_ready == (fill != CW'(DEPTH))));

  a_r6_read_path: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready) |=> (rd_rsp_valid || (mem_valid && !mem_we)));

  a_r7_rsp_after_data: assert property (@(posedge clk) disable iff (rst)
    (rd_wait && mem_rvalid) |=> (rd_rsp_valid && rd_rsp_data == $past(mem_rdata)));

  a_r10_busy_read: assert property (@(posedge clk) disable iff (rst)
    rd_wait |-> !rd_ready);

  a_r10_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind wbuf_top wbuf_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/wbuf_top_bench.sv
module wbuf_top_bench;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0, rd_valid = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0, rd_addr = '0;
  logic        st_ready, rd_ready, rd_rsp_valid, mem_valid, mem_we;
  logic [31:0] rd_rsp_data, mem_addr, mem_wdata;
  logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  wbuf_top #(.DEPTH(DEPTH), .AW(32), .DW(32)) u_wbuf_top (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: queue of stores plus a sparse memory
  logic [31:0] q_a[$], q_d[$];
  logic [31:0] mem_arr [logic [31:0]];
  bit          mon_en = 0, mem_stall = 0;
  bit          rd_out = 0, exp_rsp_next = 0, exp_mrd_next = 0, exp_nomem_next = 0, exp_wr_next = 0;
  logic [31:0] exp_rsp_data = '0, exp_mrd_addr = '0, exp_miss_data = '0, rdata_pend = '0, last_rsp = '0;
  int          cd = 0, cyc = 0, wr_to20 = 0;

  function automatic logic [31:0] memval(input logic [31:0] a);
    return mem_arr.exists(a) ? mem_arr[a] : (a ^ 32'h5A00_0000);
  endfunction

  always begin
    @(negedge clk);
    // memory side: busy one cycle in five, read data two cycles after taking a read
    mem_ready = !mem_stall && ((cyc % 5) != 2);
    cyc++;
    if (cd > 0) begin
      cd--;
      mem_rvalid = (cd == 0);
      mem_rdata  = (cd == 0) ? rdata_pend : 32'h0;
    end else begin
      mem_rvalid = 1'b0;
      mem_rdata  = 32'h0;
    end
    #2;
    if (mon_en) begin
      bit          idle_now, rsp_n, hit;
      logic [31:0] hd;
      idle_now = !mem_valid && !rd_out;
      rsp_n    = 0;
      chk(rd_rsp_valid == exp_rsp_next, "R5/R7 rsp_valid", 32'(rd_rsp_valid), 32'(exp_rsp_next));
      if (rd_rsp_valid && exp_rsp_next) begin
        chk(rd_rsp_data == exp_rsp_data, "R5/R7 rsp_data", rd_rsp_data, exp_rsp_data);
        last_rsp = rd_rsp_data;
      end
      if (exp_mrd_next)
        chk(mem_valid && !mem_we && mem_addr == exp_mrd_addr, "R6 read first", mem_addr, exp_mrd_addr);
      if (exp_nomem_next)
        chk(!(mem_valid && !mem_we), "R5 no mem read", 32'(mem_valid), 32'h0);
      if (exp_wr_next)
        chk(mem_valid && mem_we && mem_addr == q_a[0], "R4 drain start", mem_addr, q_a[0]);
      exp_mrd_next = 0; exp_nomem_next = 0; exp_wr_next = 0;
      if (rd_out) chk(!rd_ready, "R10 busy", 32'(rd_ready), 32'h0);
      if (idle_now) chk(rd_ready, "R10 idle", 32'(rd_ready), 32'h1);
      chk(st_ready == (q_a.size() < DEPTH), "R2 st_ready", 32'(st_ready), 32'(q_a.size() < DEPTH));
      // read check uses the queue before this cycle's push (R9)
      if (rd_valid && rd_ready) begin
        hit = 0; hd = '0;
        foreach (q_a[i]) if (q_a[i] == rd_addr) begin hit = 1; hd = q_d[i]; end
        if (hit) begin
          rsp_n = 1; exp_rsp_data = hd; exp_nomem_next = 1;
        end else begin
          rd_out = 1; exp_mrd_next = 1; exp_mrd_addr = rd_addr; exp_miss_data = memval(rd_addr);
        end
      end else if (idle_now && !rd_valid && q_a.size() > 0) begin
        exp_wr_next = 1;
      end
      if (mem_rvalid && rd_out) begin
        rsp_n = 1; exp_rsp_data = exp_miss_data; rd_out = 0;
      end
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          if (q_a.size() == 0) chk(0, "R3 unexpected write", mem_addr, 32'h0);
          else begin
            chk(mem_addr == q_a[0], "R3 drain addr", mem_addr, q_a[0]);
            chk(mem_wdata == q_d[0], "R3 drain data", mem_wdata, q_d[0]);
            void'(q_a.pop_front()); void'(q_d.pop_front());
          end
          if (mem_addr == 32'h20) wr_to20++;
          mem_arr[mem_addr] = mem_wdata;
        end else begin
          rdata_pend = memval(mem_addr); cd = 2;
        end
      end
      if (st_valid && st_ready) begin
        q_a.push_back(st_addr); q_d.push_back(st_data);
      end
      exp_rsp_next = rsp_n;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic st_put(input logic [31:0] a, input logic [31:0] d);
    bit acc;
    st_valid = 1'b1; st_addr = a; st_data = d;
    do begin #2; acc = st_ready; @(negedge clk); end while (!acc);
    st_valid = 1'b0;
  endtask

  task automatic rd_get(input logic [31:0] a);
    bit acc;
    rd_valid = 1'b1; rd_addr = a;
    do begin #2; acc = rd_ready; @(negedge clk); end while (!acc);
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    // R1 reset state
    chk(st_ready, "R1 st_ready", 32'(st_ready), 32'h1);
    chk(rd_ready, "R1 rd_ready", 32'(rd_ready), 32'h1);
    chk(!mem_valid, "R1 mem_valid", 32'(mem_valid), 32'h0);
    chk(!rd_rsp_valid, "R1 rsp_valid", 32'(rd_rsp_valid), 32'h0);
    @(negedge clk);
    mon_en = 1;

    // single store, free memory (R3, R4)
    st_put(32'h10, 32'h1111_0001);
    idle(8);

    // burst against a stalled memory: fill, forward, read priority (R2, R5, R6, R8)
    mem_stall = 1;
    st_put(32'h20, 32'hA000_0001);
    st_put(32'h24, 32'hA000_0002);
    st_put(32'h20, 32'hA000_0003);
    st_put(32'h28, 32'hA000_0004);
    #2; chk(!st_ready, "R2 full", 32'(st_ready), 32'h0);
    @(negedge clk);
    fork
      st_put(32'h2C, 32'hA000_0005);
      begin
        idle(2);
        rd_get(32'h20);
        rd_get(32'h24);
        rd_get(32'h30);
      end
      begin idle(10); mem_stall = 0; end
    join
    idle(30);
    chk(wr_to20 == 2, "R8 both same-address stores written", 32'(wr_to20), 32'h2);

    // same-cycle store and read to one address (R9)
    fork
      st_put(32'h40, 32'hBEEF_0040);
      rd_get(32'h40);
    join
    idle(12);
    chk(last_rsp == (32'h40 ^ 32'h5A00_0000), "R9 same-cycle store not seen", last_rsp, 32'h40 ^ 32'h5A00_0000);
    rd_get(32'h40);
    idle(8);
    chk(last_rsp == 32'hBEEF_0040, "R7 read after drain", last_rsp, 32'hBEEF_0040);

    // random mix over eight addresses
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r, a;
      r = $urandom;
      a = 32'h80 + {27'h0, r[2:0], 2'b00};
      if (r[7:5] < 3'd5) st_put(a, $urandom);
      else rd_get(a);
      idle(int'(r[9:8]));
    end
    idle(40);
    chk(q_a.size() == 0, "R3 queue drained", 32'(q_a.size()), 32'h0);
    chk(st_ready, "R2 ready when empty", 32'(st_ready), 32'h1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule